// File: doc/BRIEF.md
# Magic Divisor Constant Calculator

This block turns a 32-bit unsigned divisor into the three constants that let a downstream unit replace division by that divisor with a multiply and a shift. The three constants are a shift amount, a 32-bit multiplier and a round-down flag. The exponent is tied to the divisor's leading one, at floor(log2 d) + 32, so no search over candidate exponents is needed. The multiplier is the ceiling of 2^(shift+32) / d. When the remainder of that division is at most 2^shift, the multiplier is lowered by one and the round-down flag is set.

A caller presents a divisor together with a one-cycle `start` and waits for a one-cycle `done`. The constants stay on the outputs until the next operation completes. The quotient and remainder come from a restoring long division that yields one bit per cycle. Separate flags mark two cases. A power-of-two divisor sets one flag, so the caller can use a plain shift instead. A zero divisor sets the other, and that operation ends at once with zeroed constants.

Top module: `magicDivConst`

## Requirements
- R1: On completion for a nonzero divisor d, `shiftAmt` equals the bit index of the most significant set bit of d.
- R2: With q = floor(2^(shiftAmt+32)/d) and e = 2^(shiftAmt+32) mod d, when e > 2^shiftAmt the multiplier equals ceil(2^(shiftAmt+32)/d) and `roundDown` is 0.
- R3: When e <= 2^shiftAmt, the multiplier equals ceil(2^(shiftAmt+32)/d) - 1, taken modulo 2^32, and `roundDown` is 1.
- R4: For every nonzero divisor, bit 31 of the multiplier is 1 on completion.
- R5: For a power-of-two divisor, `powerOfTwo` is 1, the multiplier is 0xFFFFFFFF and `roundDown` is 1. For any other divisor, `powerOfTwo` is 0.
- R6: A `start` with divisor 0 raises `done` on the next cycle. It sets `divZeroErr` to 1 and drives `shiftAmt`, `multiplier`, `roundDown` and `powerOfTwo` to 0. `busy` is never raised for it.
- R7: A `start` with a nonzero divisor, sampled at clock edge k, raises `busy` from edge k until edge k+65. `done` is high for exactly the one cycle after edge k+65, and `busy` is low in that cycle. A successful completion clears `divZeroErr`.
- R8: A `start` while `busy` is high is ignored. The running operation completes with the constants of its own divisor.
- R9: The outputs `shiftAmt`, `multiplier`, `roundDown`, `powerOfTwo` and `divZeroErr` change only at the edge that raises `done`, and hold their values otherwise.
- R10: After reset, `busy`, `done` and all constant outputs and flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation on `divisor`; sampled only when idle |
| divisor | input | 32 | Divisor d |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| shiftAmt | output | 5 | floor(log2 d) |
| multiplier | output | 32 | Magic multiplier, top bit included |
| roundDown | output | 1 | Round-down correction required |
| powerOfTwo | output | 1 | Divisor is a power of two |
| divZeroErr | output | 1 | Last operation had divisor 0 |

## Verification
The hardest state to reach from the ports is the boundary of the remainder test, where e equals exactly 2^shift. At that point the round-down choice flips between R2 and R3, and it is reached only by particular divisors such as 3, 5 and 6. The stimulus therefore mixes hand-picked small divisors with the extremes 1, 2^31, 2^31+1 and 2^32-1 and with a stream of pseudo-random divisors. A second `start` is also injected in the middle of a running division, and a zero divisor is issued right after a successful operation, so that the error flag must both set and clear.

// File: rtl/magicDivPkg.sv
package magicDivPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } ctrlState_t;

  typedef struct packed {
    logic load;     // capture divisor, clear divider
    logic step;     // one restoring-division iteration
    logic finish;   // publish constants
    logic zeroErr;  // publish zero-divisor error
  } ctrlStrobes_t;

endpackage

// File: rtl/magicDivDatapath.sv
module magicDivDatapath
  import magicDivPkg::*;
#(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [W-1:0]         divisorIn,
  output logic                 dIsZero,
  output logic                 lastStep,
  output logic [$clog2(W)-1:0] shiftOut,
  output logic [W-1:0]         multOut,
  output logic                 roundDownOut,
  output logic                 pow2Out,
  output logic                 errOut
);

  localparam int SW = $clog2(W);
  localparam int CW = $clog2(2 * W);
  localparam logic [CW-1:0] CNT_TOP = CW'(2 * W - 1);

  logic [W-1:0]  dReg;
  logic [SW-1:0] shiftReg;
  logic [CW-1:0] cnt;
  logic [W-1:0]  rem;
  logic [W:0]    quot;

  // Leading-one detector: highest set bit wins.
  logic [SW-1:0] leadPos;
  always_comb begin
    leadPos = '0;
    for (int i = 0; i < W; i++) begin
      if (divisorIn[i]) leadPos = SW'(i);
    end
  end

  assign dIsZero  = (divisorIn == '0);
  assign lastStep = (cnt == '0);

  // Dividend 2^(W+shift) has a single one at bit W+shift.
  logic          bitIn;
  logic [W:0]    trial;
  logic [W:0]    diff;
  logic          ge;
  logic [W-1:0]  newRem;
  assign bitIn  = (cnt == (CW'(W) + CW'(shiftReg)));
  assign trial  = {rem, bitIn};
  assign diff   = trial - {1'b0, dReg};
  assign ge     = (trial >= {1'b0, dReg});
  assign newRem = ge ? diff[W-1:0] : trial[W-1:0];

  // Final constant selection.
  logic [W-1:0] thresh;
  logic         rdSel;
  logic         isPow2;
  logic [W-1:0] multSel;
  assign thresh  = W'(1) << shiftReg;
  assign rdSel   = (rem <= thresh);
  assign isPow2  = ((dReg & (dReg - W'(1))) == '0);
  assign multSel = isPow2 ? '1 : (rdSel ? quot[W-1:0] : quot[W-1:0] + W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dReg     <= '0;
      shiftReg <= '0;
      cnt      <= '0;
      rem      <= '0;
      quot     <= '0;
    end else if (strobes.load) begin
      dReg     <= divisorIn;
      shiftReg <= leadPos;
      cnt      <= CNT_TOP;
      rem      <= '0;
      quot     <= '0;
    end else if (strobes.step) begin
      cnt      <= cnt - CW'(1);
      rem      <= newRem;
      quot     <= {quot[W-1:0], ge};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftOut     <= '0;
      multOut      <= '0;
      roundDownOut <= 1'b0;
      pow2Out      <= 1'b0;
      errOut       <= 1'b0;
    end else if (strobes.zeroErr) begin
      shiftOut     <= '0;
      multOut      <= '0;
      roundDownOut <= 1'b0;
      pow2Out      <= 1'b0;
      errOut       <= 1'b1;
    end else if (strobes.finish) begin
      shiftOut     <= shiftReg;
      multOut      <= multSel;
      roundDownOut <= rdSel;
      pow2Out      <= isPow2;
      errOut       <= 1'b0;
    end
  end

  // R4
  mult_top_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finish |=> multOut[W-1]);

  // R5
  pow2_const_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finish |=> (!pow2Out || (multOut == '1 && roundDownOut)));

  // R6
  zero_div_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.zeroErr |=> (errOut && multOut == '0 && shiftOut == '0 && !pow2Out && !roundDownOut));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(multOut) |-> ($past(strobes.finish) || $past(strobes.zeroErr)));

endmodule

// File: rtl/magicDivCtrl.sv
module magicDivCtrl
  import magicDivPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startIn,
  input  logic         dIsZero,
  input  logic         lastStep,
  output ctrlStrobes_t strobes,
  output logic         busyOut,
  output logic         doneOut
);

  ctrlState_t state, stateNext;

  always_comb begin
    strobes         = '0;
    stateNext       = state;
    case (state)
      ST_IDLE: begin
        if (startIn) begin
          if (dIsZero) strobes.zeroErr = 1'b1;
          else begin
            strobes.load = 1'b1;
            stateNext    = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        strobes.step = 1'b1;
        if (lastStep) stateNext = ST_FIN;
      end
      ST_FIN: begin
        strobes.finish = 1'b1;
        stateNext      = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      doneOut <= 1'b0;
    end else begin
      state   <= stateNext;
      doneOut <= strobes.finish | strobes.zeroErr;
    end
  end

  assign busyOut = (state != ST_IDLE);

  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busyOut && doneOut));

  // R8
  run_ignores_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !lastStep) |=> (state == ST_RUN));

  // R6
  zero_no_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && startIn && dIsZero) |=> (!busyOut && doneOut));

endmodule

// File: rtl/magicDivConst.sv
module magicDivConst
  import magicDivPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [31:0] divisor,
  output logic        busy,
  output logic        done,
  output logic [4:0]  shiftAmt,
  output logic [31:0] multiplier,
  output logic        roundDown,
  output logic        powerOfTwo,
  output logic        divZeroErr
);

  ctrlStrobes_t strobes;
  logic         dIsZero;
  logic         lastStep;

  magicDivCtrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .startIn  (start),
    .dIsZero  (dIsZero),
    .lastStep (lastStep),
    .strobes  (strobes),
    .busyOut  (busy),
    .doneOut  (done)
  );

  magicDivDatapath #(.W(32)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .divisorIn    (divisor),
    .dIsZero      (dIsZero),
    .lastStep     (lastStep),
    .shiftOut     (shiftAmt),
    .multOut      (multiplier),
    .roundDownOut (roundDown),
    .pow2Out      (powerOfTwo),
    .errOut       (divZeroErr)
  );

endmodule

// File: tb/magicDivConst_tb_top.sv
`timescale 1ns/1ps
module magicDivConst_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] divisor = '0;
  logic        busy, done, roundDown, powerOfTwo, divZeroErr;
  logic [4:0]  shiftAmt;
  logic [31:0] multiplier;

  int compared = 0;
  int mismatched = 0;
  bit pokePhase = 1'b0;

  always #2.5 clk = ~clk;

  magicDivConst dut_i (
    .clk(clk), .rstN(rstN), .start(start), .divisor(divisor),
    .busy(busy), .done(done), .shiftAmt(shiftAmt), .multiplier(multiplier),
    .roundDown(roundDown), .powerOfTwo(powerOfTwo), .divZeroErr(divZeroErr)
  );

  // Behavioural reference model
  int          mPhase = 0;
  logic [31:0] mD = '0;
  bit          mDone = 0, mRd = 0, mPow2 = 0, mErr = 0;
  logic [4:0]  mShift = '0;
  logic [31:0] mMult = '0;
  string       mTag = "R10";

  task automatic computeConst(input logic [31:0] d);
    logic [63:0] n, q, e, m;
    int s;
    s = 0;
    for (int b = 0; b < 32; b++) if (d[b]) s = b;
    n = 64'd1 << (s + 32);
    q = n / {32'd0, d};
    e = n % {32'd0, d};
    m = q + ((e != 0) ? 64'd1 : 64'd0);
    mShift = 5'(s);
    mRd    = (e <= (64'd1 << s));
    mMult  = mRd ? 32'(m - 64'd1) : 32'(m);
    mPow2  = ((d & (d - 32'd1)) == 32'd0);
    mErr   = 0;
    if (mPow2) mTag = "R5";
    else if (mRd) mTag = "R3";
    else mTag = "R2";
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mDone = 0; mRd = 0; mPow2 = 0; mErr = 0;
      mShift = '0; mMult = '0; mTag = "R10";
    end else begin
      mDone = 0;
      if (mPhase == 0) begin
        if (start) begin
          if (divisor == 32'd0) begin
            mShift = '0; mMult = '0; mRd = 0; mPow2 = 0; mErr = 1;
            mDone = 1; mTag = "R6";
          end else begin
            mD = divisor;
            mPhase = 1;
          end
        end
      end else if (mPhase == 65) begin
        computeConst(mD);
        mDone = 1;
        mPhase = 0;
      end else begin
        mPhase = mPhase + 1;
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Compare on every falling edge
  always @(negedge clk) begin
    string ot, ct;
    if (!rstN) begin
      ot = "R10"; ct = "R10";
    end else if (pokePhase) begin
      ot = "R8"; ct = "R8";
    end else if (mDone) begin
      ot = mTag; ct = "R7";
    end else begin
      ot = "R9"; ct = "R7";
    end
    chk(ct, "busy", 32'(busy), 32'(mPhase != 0));
    chk(ct, "done", 32'(done), 32'(mDone));
    chk(mDone ? "R1" : ot, "shiftAmt", 32'(shiftAmt), 32'(mShift));
    chk(ot, "multiplier", multiplier, mMult);
    chk(ot, "roundDown", 32'(roundDown), 32'(mRd));
    chk(ot, "powerOfTwo", 32'(powerOfTwo), 32'(mPow2));
    chk(mErr ? "R6" : ot, "divZeroErr", 32'(divZeroErr), 32'(mErr));
    if (rstN && done && !divZeroErr) chk("R4", "multiplier[31]", 32'(multiplier[31]), 32'd1);
  end

  task automatic runOne(input logic [31:0] d);
    @(negedge clk);
    start = 1'b1;
    divisor = d;
    @(negedge clk);
    start = 1'b0;
    divisor = ~d;
    if (!done) begin
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (done) break;
      end
    end
  endtask

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 R2 R3 R5 boundary and typical divisors
    runOne(32'd1);
    runOne(32'd2);
    runOne(32'd3);
    runOne(32'd5);
    runOne(32'd6);
    runOne(32'd7);
    runOne(32'd11);
    runOne(32'd70);
    runOne(32'h8000_0000);
    runOne(32'h8000_0001);
    runOne(32'hFFFF_FFFF);
    // R6 zero divisor, then recovery clears the flag (R7)
    runOne(32'd0);
    runOne(32'd0);
    runOne(32'd641);
    // R8 start while busy
    @(negedge clk);
    start = 1'b1; divisor = 32'd11;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    pokePhase = 1'b1;
    start = 1'b1; divisor = 32'd3;
    @(negedge clk);
    start = 1'b0; divisor = 32'd0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (done) break;
    end
    pokePhase = 1'b0;
    // pseudo-random divisors
    lfsr = 32'hACE1_2345;
    for (int k = 0; k < 30; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      runOne(lfsr >> (k % 29));
    end
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 5);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule